// File: doc/BRIEF.md
# Memory Bank Select Decoder

This block decides, for every processor bus access, which of five memory resources answers it: the main RAM, a lower ROM in the window $A000-$BFFF, an upper ROM in $E000-$FFFF, a character (glyph) ROM, or the I/O register area. The glyph ROM and the I/O area share the window $D000-$DFFF. Three mapping bits from the processor's on-chip port steer the choice. The bits act together rather than independently. Clearing the high-map bit removes both ROM windows. Clearing the low-map and high-map bits together also removes the I/O and glyph window, so that the whole address space is RAM.

Writes never reach a ROM. A write into a ROM window lands in the RAM underneath it. A write into the shared window reaches the I/O area only while I/O is mapped in, and reaches RAM in every other case.

The decode is combinational. Its result goes into one register clocked by the system clock, and the phase-high input gates that register. A clock edge that samples phase high produces exactly one active chip select on the next cycle. A clock edge that samples phase low produces none. The block has no streaming data path: every pin is a plain level signal with no handshake and no back-pressure.

Top module: `bank_select_decoder`

## Requirements
- R1: While rst_ni is low at a rising clock edge, cs_o is all zero after that edge.
- R2: When phase_hi_i is 0 at a rising edge, cs_o is all zero after that edge.
- R3: When phase_hi_i is 1 at a rising edge, exactly one bit of cs_o is set after that edge. The bit positions are: 0 = RAM, 1 = lower ROM, 2 = upper ROM, 3 = glyph ROM, 4 = I/O. The output follows the inputs sampled at that edge, a latency of one cycle.
- R4: A read in $A000-$BFFF selects the lower ROM (bit 1) when map_low_i and map_high_i are both 1. Otherwise it selects RAM (bit 0).
- R5: A read in $E000-$FFFF selects the upper ROM (bit 2) when map_high_i is 1, and RAM when it is 0.
- R6: With map_high_i at 0, a read in $A000-$BFFF selects RAM even when map_low_i is 1.
- R7: In $D000-$DFFF, with map_io_i at 1 and at least one of map_low_i or map_high_i at 1, both reads and writes select I/O (bit 4).
- R8: In $D000-$DFFF, with map_io_i at 0 and at least one of map_low_i or map_high_i at 1, a read selects the glyph ROM (bit 3) and a write selects RAM.
- R9: In $D000-$DFFF, with map_low_i and map_high_i both 0, every access selects RAM, whatever the value of map_io_i.
- R10: A write (read_i = 0) in $A000-$BFFF or $E000-$FFFF selects RAM.
- R11: Every address outside $A000-$BFFF, $D000-$DFFF and $E000-$FFFF selects RAM, whatever the mapping bits are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| phase_hi_i | input | 1 | High while a bus access is valid |
| addr_i | input | 16 | Processor address |
| read_i | input | 1 | 1 = read, 0 = write |
| map_low_i | input | 1 | Low-map bit of the processor port |
| map_high_i | input | 1 | High-map bit of the processor port |
| map_io_i | input | 1 | Selects I/O (1) or glyph ROM (0) in the shared window |
| cs_o | output | 5 | Registered one-hot chip selects |

## Verification
The assertions check on every cycle that the output is idle after a phase-low edge and exactly one-hot after a phase-high edge. They also check that writes never raise a ROM select, that clearing the high-map bit blocks the lower ROM, and that clearing both low bits sends the shared window to RAM. Only the bench's scenarios can show that each region and mapping combination reaches the right resource. The bench covers every one of the eight mapping-bit combinations, both access directions, and addresses at the edges of each window, including the boundary values $9FFF, $C000, $CFFF and $FFFF.

// File: rtl/bank_select_pkg.sv
package bank_select_pkg;
  typedef enum logic [2:0] {
    TGT_RAM   = 3'd0,
    TGT_LOROM = 3'd1,
    TGT_HIROM = 3'd2,
    TGT_GLYPH = 3'd3,
    TGT_IO    = 3'd4
  } target_e;

  localparam int NUM_CS = 5;

  typedef enum logic [1:0] {
    REG_PLAIN  = 2'd0,
    REG_LOWWIN = 2'd1,
    REG_SHARED = 2'd2,
    REG_HIWIN  = 2'd3
  } region_e;
endpackage

// File: rtl/bank_region.sv
module bank_region
  import bank_select_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NIB_W = 4,
  parameter logic [NIB_W-1:0] LOW_BASE = 4'hA,
  parameter int LOW_SPAN = 2,
  parameter logic [NIB_W-1:0] SHARED_BASE = 4'hD,
  parameter int SHARED_SPAN = 1,
  parameter logic [NIB_W-1:0] HIGH_BASE = 4'hE,
  parameter int HIGH_SPAN = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o
);
  localparam int LOW_END = int'(LOW_BASE) + LOW_SPAN;
  localparam int SHARED_END = int'(SHARED_BASE) + SHARED_SPAN;
  localparam int HIGH_END = int'(HIGH_BASE) + HIGH_SPAN;

  logic [NIB_W-1:0] nib;
  int nib_int;

  assign nib = addr_i[ADDR_W-1 -: NIB_W];
  assign nib_int = int'(nib);

  always_comb begin
    region_o = REG_PLAIN;
    if (nib_int >= int'(LOW_BASE) && nib_int < LOW_END)
      region_o = REG_LOWWIN;
    else if (nib_int >= int'(SHARED_BASE) && nib_int < SHARED_END)
      region_o = REG_SHARED;
    else if (nib_int >= int'(HIGH_BASE) && nib_int < HIGH_END)
      region_o = REG_HIWIN;
  end
endmodule

// File: rtl/bank_policy.sv
module bank_policy
  import bank_select_pkg::*;
(
  input  region_e region_i,
  input  logic    read_i,
  input  logic    map_low_i,
  input  logic    map_high_i,
  input  logic    map_io_i,
  output target_e target_o
);
  logic shared_live;

  assign shared_live = map_low_i | map_high_i;

  always_comb begin
    target_o = TGT_RAM;
    unique case (region_i)
      REG_LOWWIN: if (read_i && map_low_i && map_high_i) target_o = TGT_LOROM;
      REG_HIWIN:  if (read_i && map_high_i) target_o = TGT_HIROM;
      REG_SHARED: begin
        if (shared_live) begin
          if (map_io_i)    target_o = TGT_IO;
          else if (read_i) target_o = TGT_GLYPH;
        end
      end
      default: target_o = TGT_RAM;
    endcase
  end
endmodule

// File: rtl/bank_cs_reg.sv
module bank_cs_reg
  import bank_select_pkg::*;
#(
  parameter int N = NUM_CS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         phase_hi_i,
  input  target_e      target_i,
  output logic [N-1:0] cs_o
);
  logic [N-1:0] hot;

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign hot[g] = (target_i == target_e'(g));
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)         cs_o <= '0;
    else if (phase_hi_i) cs_o <= hot;
    else                 cs_o <= '0;
  end
endmodule

// File: rtl/bank_select_decoder.sv
module bank_select_decoder
  import bank_select_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              phase_hi_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              read_i,
  input  logic              map_low_i,
  input  logic              map_high_i,
  input  logic              map_io_i,
  output logic [NUM_CS-1:0] cs_o
);
  region_e region;
  target_e target;

  bank_region #(.ADDR_W(ADDR_W)) u_region (
    .addr_i  (addr_i),
    .region_o(region)
  );

  bank_policy u_policy (
    .region_i  (region),
    .read_i    (read_i),
    .map_low_i (map_low_i),
    .map_high_i(map_high_i),
    .map_io_i  (map_io_i),
    .target_o  (target)
  );

  bank_cs_reg #(.N(NUM_CS)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_hi_i(phase_hi_i),
    .target_i  (target),
    .cs_o      (cs_o)
  );
endmodule

// File: rtl/bank_select_decoder_chk.sv
module bank_select_decoder_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              phase_hi_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              read_i,
  input logic              map_low_i,
  input logic              map_high_i,
  input logic              map_io_i,
  input logic [4:0]        cs_o
);
  logic in_shared;
  assign in_shared = (addr_i[ADDR_W-1 -: 4] == 4'hD);

  assert_idle_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_hi_i |=> (cs_o == 5'b0));

  assert_one_hot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_hi_i |=> ($countones(cs_o) == 1));

  assert_never_multi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o));

  assert_no_lorom_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !map_high_i |=> !cs_o[1]);

  assert_write_no_rom_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_hi_i && !read_i) |=> (cs_o[3:1] == 3'b0));

  assert_shared_ram_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_hi_i && in_shared && !map_low_i && !map_high_i) |=> cs_o[0]);
endmodule

bind bank_select_decoder bank_select_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/bank_select_decoder_bench.sv
`timescale 1ns/1ps
module bank_select_decoder_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        phase = 0;
  logic [15:0] addr = '0;
  logic        rd = 1;
  logic        mlo = 1, mhi = 1, mio = 1;
  logic [4:0]  cs;

  int tests = 0;
  int fails = 0;
  logic [4:0] pend_exp = '0;
  string      pend_tag = "R1";
  logic       pend_live = 0;
  logic       have_pend = 0;

  always #2.5 clk = ~clk;

  bank_select_decoder u_bank_select_decoder (
    .clk_i(clk), .rst_ni(rst_n), .phase_hi_i(phase), .addr_i(addr),
    .read_i(rd), .map_low_i(mlo), .map_high_i(mhi), .map_io_i(mio), .cs_o(cs)
  );

  function automatic int model_idx(int a, bit r, bit lo, bit hi, bit io);
    if (a >= 'hA000 && a <= 'hBFFF) return (r && lo && hi) ? 1 : 0;
    if (a >= 'hE000 && a <= 'hFFFF) return (r && hi) ? 2 : 0;
    if (a >= 'hD000 && a <= 'hDFFF) begin
      if (!lo && !hi) return 0;
      if (io) return 4;
      return r ? 3 : 0;
    end
    return 0;
  endfunction

  function automatic string model_tag(bit rs, bit p, int a, bit r, bit lo, bit hi, bit io);
    if (!rs) return "R1";
    if (!p) return "R2";
    if (a >= 'hA000 && a <= 'hBFFF) return !r ? "R10" : (hi ? "R4" : "R6");
    if (a >= 'hE000 && a <= 'hFFFF) return r ? "R5" : "R10";
    if (a >= 'hD000 && a <= 'hDFFF) return (!lo && !hi) ? "R9" : (io ? "R7" : "R8");
    return "R11";
  endfunction

  task automatic step(bit rs, bit p, logic [15:0] a, bit r, bit lo, bit hi, bit io);
    @(negedge clk);
    if (have_pend) begin
      tests++;
      if (cs !== pend_exp) begin
        fails++;
        $display("FAIL %s: cs_o=%b expected %b", pend_tag, cs, pend_exp);
      end
      if (pend_live) begin
        tests++;
        if ($countones(cs) != 1) begin
          fails++;
          $display("FAIL R3: cs_o=%b expected exactly one bit set", cs);
        end
      end
    end
    rst_n = rs; phase = p; addr = a; rd = r; mlo = lo; mhi = hi; mio = io;
    pend_exp = (rs && p) ? (5'b1 << model_idx(int'(a), r, lo, hi, io)) : 5'b0;
    pend_tag = model_tag(rs, p, int'(a), r, lo, hi, io);
    pend_live = rs && p;
    have_pend = 1;
  endtask

  initial begin : watchdog
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    logic [15:0] edges [12] = '{16'h0000, 16'h9FFF, 16'hA000, 16'hBFFF, 16'hC000,
                                16'hCFFF, 16'hD000, 16'hD7A5, 16'hDFFF, 16'hE000,
                                16'hF123, 16'hFFFF};
    // R1: phase high but reset held
    for (int i = 0; i < 4; i++) step(0, 1, 16'hA000, 1, 1, 1, 1);
    // directed sweep over all mapping bits, directions, window edges
    for (int m = 0; m < 8; m++)
      for (int r = 0; r < 2; r++)
        for (int e = 0; e < 12; e++) begin
          step(1, 1, edges[e], r[0], m[0], m[1], m[2]);
          step(1, 0, edges[e], r[0], m[0], m[1], m[2]); // R2
        end
    // back-to-back phase-high accesses
    for (int e = 0; e < 12; e++) step(1, 1, edges[e], 1, 1, 0, 1);
    // mid-run reset
    step(0, 1, 16'hE000, 1, 1, 1, 1);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] v = $urandom;
      step(1, v[20] | v[21], v[15:0], v[16], v[17], v[18], v[19]);
    end
    step(1, 0, 16'h0000, 1, 1, 1, 1);
    step(1, 0, 16'h0000, 1, 1, 1, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule